// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block runs one external bus cycle at a time for a processor-side requester. A request (address, read/write, transfer size, transfer code) is accepted while the block is idle. The request is then held on the bus outputs until the cycle is terminated. Termination comes from a normal acknowledge or an error acknowledge. Each of these can come from an external pin or from an internal source. A built-in bus monitor raises an error of its own when no acknowledge arrives within a programmable number of clocks.

The requester sees the end of a cycle as a one-clock `done` pulse, with `err` marking an error ending. If the requester abandons a cycle, the bus outputs stay driven and unchanged until the cycle would have ended, and no completion is reported.

A 2-bit emulation chip-select tells an external tracker which address region a cycle targets. This output is active only when emulation mode is enabled.

The controller has three states:
- **IDLE**: no cycle in progress.
- **RUN**: a cycle in progress whose completion will be reported.
- **ABANDON**: an aborted cycle that still drives the bus.

It has four transitions:
- **IDLE→RUN**: request accepted.
- **RUN→IDLE**: termination, reported through `done`.
- **RUN→ABANDON**: abort at an edge that has no termination.
- **ABANDON→IDLE**: termination, not reported.

Top module: `bus_term_ctrl`

## Requirements
- R1: A `req_valid` seen at a rising edge while idle starts a cycle. From the next cycle onward, `bus_drive` is 1 and `bus_addr`, `bus_write`, `bus_size` and `bus_code` show the request, with `bus_oe` = 1 exactly for reads. A `req_valid` that arrives while a cycle is in progress is ignored.
- R2: Sampling edge k is the k-th rising edge after the edge that accepted the request. If `ack_pin` or `ack_int` is high at a sampling edge, the cycle ends there. In the following clock, `done` = 1, `err` = 0 and `bus_drive` = 0, and `done` stays high for exactly one clock.
- R3: If `err_pin` or `err_int` is high at a sampling edge, the cycle ends with `done` = 1 and `err` = 1.
- R4: When a normal acknowledge and an error acknowledge are both high at the same sampling edge, the cycle ends with `err` = 1.
- R5: With `timeout_lim` = N ≠ 0 (captured when the request is accepted) and no acknowledge by sampling edge N, edge N ends the cycle with `err` = 1. A normal acknowledge at edge N still gives `err` = 1. N = 0 disables the monitor.
- R6: If `req_abort` is high at a sampling edge that has no termination, the cycle becomes abandoned. The bus outputs stay driven and unchanged until a later termination, which may be a monitor timeout. That termination releases the bus with no `done` pulse. When a termination and an abort arrive at the same edge, the termination is reported normally.
- R7: Acknowledges of either kind that arrive while idle have no effect: `done` and `bus_drive` stay 0.
- R8: `cse` reports the region of the cycle in progress, but only while `emu_mode` was 1 when the request was accepted. The codes are:
  - 2'b10 for port registers, 0x00C0_0000 to 0x00C0_FFFF.
  - 2'b11 for other internal module registers, 0x00C1_0000 to 0x00CF_FFFF.
  - 2'b01 for any other address below 0x0100_0000.
  - 2'b00 for all other addresses, when emulation mode is off, or when idle.
- R9: After reset, `done`, `err`, `bus_drive`, `bus_oe` and `cse` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Transfer size |
| req_code | input | 3 | Transfer code |
| req_abort | input | 1 | Requester abandons the current cycle |
| emu_mode | input | 1 | Emulation or master mode enable |
| timeout_lim | input | 8 | Monitor limit in sampling edges, 0 = off |
| ack_pin | input | 1 | Normal acknowledge, external |
| ack_int | input | 1 | Normal acknowledge, internal |
| err_pin | input | 1 | Error acknowledge, external |
| err_int | input | 1 | Error acknowledge, internal |
| bus_drive | output | 1 | Bus outputs are being driven |
| bus_addr | output | 32 | Held address |
| bus_write | output | 1 | Held read/write |
| bus_size | output | 2 | Held transfer size |
| bus_code | output | 3 | Held transfer code |
| bus_oe | output | 1 | Output enable, reads only |
| cse | output | 2 | Emulation chip-select region code |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Completion was an error |

## Verification
A state register stuck in RUN or ABANDON shows up as `bus_drive` staying high beyond the expected termination edge, within one clock of that edge. A monitor counter that is off by one moves the error ending one sampling edge early or late. The ending edge is observed cycle by cycle, so that shows up at once. A wrong ABANDON entry or exit either produces a `done` pulse that should not exist, or loses one that should, in the clock after termination. A wrong latch or decode shows on `bus_addr` or `cse` in the first clock of the cycle.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_RUN     = 2'b01,
        ST_ABANDON = 2'b10
    } term_state_t;

    typedef enum logic [1:0] {
        CSE_EXT    = 2'b00,
        CSE_INTMEM = 2'b01,
        CSE_PORT   = 2'b10,
        CSE_MODREG = 2'b11
    } cse_code_t;

endpackage

// File: rtl/bus_term_decode.sv
module bus_term_decode
    import bus_term_pkg::*;
#(
    parameter int             AW        = 32,
    parameter logic [AW-1:0]  PORT_BASE = 32'h00C0_0000,
    parameter logic [AW-1:0]  PORT_MASK = 32'hFFFF_0000,
    parameter logic [AW-1:0]  MOD_BASE  = 32'h00C0_0000,
    parameter logic [AW-1:0]  MOD_MASK  = 32'hFFF0_0000,
    parameter logic [AW-1:0]  INT_BASE  = 32'h0000_0000,
    parameter logic [AW-1:0]  INT_MASK  = 32'hFF00_0000
) (
    input  logic [AW-1:0] addr,
    input  logic          emu_en,
    output cse_code_t     code
);

    logic hit_port;
    logic hit_mod;
    logic hit_int;

    assign hit_port = (addr & PORT_MASK) == PORT_BASE;
    assign hit_mod  = (addr & MOD_MASK)  == MOD_BASE;
    assign hit_int  = (addr & INT_MASK)  == INT_BASE;

    // Ports sit inside module space, which sits inside internal space:
    // the narrowest match wins.
    always_comb begin
        if (!emu_en)       code = CSE_EXT;
        else if (hit_port) code = CSE_PORT;
        else if (hit_mod)  code = CSE_MODREG;
        else if (hit_int)  code = CSE_INTMEM;
        else               code = CSE_EXT;
    end

endmodule

// File: rtl/bus_term_mon.sv
module bus_term_mon #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          running,
    input  logic [TW-1:0] lim_in,
    output logic          expired
);

    logic [TW-1:0] lim_q;
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    lim_q <= '0;
        else if (load) lim_q <= lim_in;
    end

    // Counts sampling edges already passed in the current cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!running)   cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + 1'b1;
    end

    assign expired = running && (lim_q != '0) && (cnt == lim_q - 1'b1);

    // R5: the count never passes the limit while a cycle is live.
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (running && lim_q != '0) |-> (cnt < lim_q));

endmodule

// File: rtl/bus_term_fsm.sv
module bus_term_fsm
    import bus_term_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        abort,
    input  logic        ack_any,
    input  logic        err_any,
    output term_state_t state,
    output logic        load,
    output logic        done,
    output logic        err
);

    term_state_t state_nx;
    logic        term;

    assign term = ack_any || err_any;
    assign load = (state == ST_IDLE) && start;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_RUN;
            ST_RUN: begin
                if (term)       state_nx = ST_IDLE;
                else if (abort) state_nx = ST_ABANDON;
            end
            ST_ABANDON: if (term) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= (state == ST_RUN) && term;
            err  <= (state == ST_RUN) && err_any;
        end
    end

    // R2: a completion pulse lasts one clock.
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3: an error flag only accompanies a completion.
    a_r3_err_has_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    // R4: error termination wins over normal termination.
    a_r4_error_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && err_any) |=> (done && err));
    // R7: nothing is reported from the idle state.
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !done);
    // R6: an abandoned cycle ends silently.
    a_r6_abandon_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ABANDON) |=> !done);

endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
    import bus_term_pkg::*;
#(
    parameter int AW = 32,
    parameter int TW = 8,
    parameter int SW = 2,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic [SW-1:0] req_size,
    input  logic [CW-1:0] req_code,
    input  logic          req_abort,
    input  logic          emu_mode,
    input  logic [TW-1:0] timeout_lim,
    input  logic          ack_pin,
    input  logic          ack_int,
    input  logic          err_pin,
    input  logic          err_int,
    output logic          bus_drive,
    output logic [AW-1:0] bus_addr,
    output logic          bus_write,
    output logic [SW-1:0] bus_size,
    output logic [CW-1:0] bus_code,
    output logic          bus_oe,
    output logic [1:0]    cse,
    output logic          done,
    output logic          err
);

    term_state_t   state;
    logic          load;
    logic          expired;
    logic          ack_any;
    logic          err_any;
    cse_code_t     cse_d;
    cse_code_t     cse_q;
    logic [AW-1:0] addr_q;
    logic          write_q;
    logic [SW-1:0] size_q;
    logic [CW-1:0] code_q;

    assign ack_any = ack_pin || ack_int;
    assign err_any = err_pin || err_int || expired;

    bus_term_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (req_valid),
        .abort   (req_abort),
        .ack_any (ack_any),
        .err_any (err_any),
        .state   (state),
        .load    (load),
        .done    (done),
        .err     (err)
    );

    bus_term_mon #(.TW(TW)) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .running (state != ST_IDLE),
        .lim_in  (timeout_lim),
        .expired (expired)
    );

    bus_term_decode #(.AW(AW)) u_dec (
        .addr   (req_addr),
        .emu_en (emu_mode),
        .code   (cse_d)
    );

    // Request capture: held unchanged for the whole cycle, abandoned or not.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            size_q  <= '0;
            code_q  <= '0;
            cse_q   <= CSE_EXT;
        end else if (load) begin
            addr_q  <= req_addr;
            write_q <= req_write;
            size_q  <= req_size;
            code_q  <= req_code;
            cse_q   <= cse_d;
        end
    end

    assign bus_drive = (state != ST_IDLE);
    assign bus_addr  = addr_q;
    assign bus_write = write_q;
    assign bus_size  = size_q;
    assign bus_code  = code_q;
    assign bus_oe    = bus_drive && !write_q;
    assign cse       = bus_drive ? cse_q : CSE_EXT;

    // R1 and R6: bus values stay put while a cycle remains driven.
    a_r6_hold_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drive && $past(bus_drive)) |->
            ($stable(bus_addr) && $stable(bus_write) && $stable(bus_size) && $stable(bus_code)));
    // R2: a reported completion always releases the bus.
    a_r2_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_drive);

endmodule

// File: tb/bus_term_ctrl_tb.sv
module bus_term_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [2:0]  req_code = '0;
    logic        req_abort = 1'b0;
    logic        emu_mode = 1'b0;
    logic [7:0]  timeout_lim = '0;
    logic        ack_pin = 1'b0;
    logic        ack_int = 1'b0;
    logic        err_pin = 1'b0;
    logic        err_int = 1'b0;
    logic        bus_drive;
    logic [31:0] bus_addr;
    logic        bus_write;
    logic [1:0]  bus_size;
    logic [2:0]  bus_code;
    logic        bus_oe;
    logic [1:0]  cse;
    logic        done;
    logic        err;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    bus_term_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_code(req_code),
        .req_abort(req_abort), .emu_mode(emu_mode), .timeout_lim(timeout_lim),
        .ack_pin(ack_pin), .ack_int(ack_int), .err_pin(err_pin), .err_int(err_int),
        .bus_drive(bus_drive), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_size(bus_size), .bus_code(bus_code), .bus_oe(bus_oe), .cse(cse),
        .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a, input bit w, input logic [7:0] lim);
        req_addr = a; req_write = w; req_size = 2'b10; req_code = 3'b101;
        timeout_lim = lim; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // kind: 0 none, 1 ack_pin, 2 ack_int, 3 err_pin, 4 err_int, 5 ack_pin+err_int
    task automatic run_one(input string tag, input logic [31:0] a, input bit w,
                           input int kind, input int ack_at, input logic [7:0] lim,
                           input int abort_at, input int exp_k,
                           input bit exp_done, input bit exp_err);
        int end_k = 0;
        bit got_done = 0;
        bit got_err = 0;
        bit held = 1;
        issue(a, w, lim);
        chk(bus_drive == 1'b1, "R1", "drive after accept", bus_drive, 1);
        chk(bus_addr == a && bus_write == w && bus_size == 2'b10 && bus_code == 3'b101,
            "R1", "request on bus", bus_addr, a);
        chk(bus_oe == !w, "R1", "oe for reads", bus_oe, !w);
        for (int k = 1; k <= 40 && end_k == 0; k++) begin
            ack_pin   = (k == ack_at) && (kind == 1 || kind == 5);
            ack_int   = (k == ack_at) && (kind == 2);
            err_pin   = (k == ack_at) && (kind == 3);
            err_int   = (k == ack_at) && (kind == 4 || kind == 5);
            req_abort = (k == abort_at);
            @(negedge clk);
            ack_pin = 0; ack_int = 0; err_pin = 0; err_int = 0; req_abort = 0;
            if (!bus_drive) begin
                end_k = k; got_done = done; got_err = err;
            end else if (bus_addr != a || bus_oe != !w) begin
                held = 0;
            end
        end
        chk(end_k == exp_k, tag, "ending edge", end_k, exp_k);
        chk(got_done == exp_done, tag, "done at end", got_done, exp_done);
        if (exp_done) chk(got_err == exp_err, tag, "err at end", got_err, exp_err);
        if (abort_at > 0) chk(held, "R6", "pins held while abandoned", held, 1);
        @(negedge clk);
        chk(done == 1'b0, "R2", "done lasts one clock", done, 0);
    endtask

    task automatic test_idle_acks();
        for (int i = 0; i < 3; i++) begin
            ack_pin = 1; ack_int = 1; err_pin = 1; err_int = 1;
            @(negedge clk);
            chk(done == 1'b0 && bus_drive == 1'b0, "R7", "idle acknowledge ignored", done, 0);
        end
        ack_pin = 0; ack_int = 0; err_pin = 0; err_int = 0;
        @(negedge clk);
        chk(done == 1'b0, "R7", "no late done", done, 0);
    endtask

    task automatic test_busy_request();
        issue(32'h1234_5670, 1'b1, 8'd0);
        req_valid = 1'b1; req_addr = 32'hABCD_0000; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_addr == 32'h1234_5670 && bus_write == 1'b1, "R1", "busy request ignored",
            bus_addr, 32'h1234_5670);
        ack_pin = 1;
        @(negedge clk);
        ack_pin = 0;
        chk(done == 1'b1 && bus_drive == 1'b0, "R1", "cycle ended", done, 1);
        @(negedge clk);
        chk(bus_drive == 1'b0, "R1", "stale request not started", bus_drive, 0);
    endtask

    task automatic test_cse(input logic [31:0] a, input bit m, input logic [1:0] exp);
        emu_mode = m;
        issue(a, 1'b0, 8'd0);
        chk(cse == exp, "R8", $sformatf("region of %h", a), cse, exp);
        emu_mode = 1'b0;
        ack_pin = 1;
        @(negedge clk);
        ack_pin = 0;
        chk(cse == 2'b00, "R8", "idle code", cse, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 0 && err == 0 && bus_drive == 0 && bus_oe == 0 && cse == 0,
            "R9", "reset outputs", {done, err, bus_drive, bus_oe, cse}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_one("R2", 32'h0000_1000, 1'b0, 1, 1, 8'd0, 0, 1, 1'b1, 1'b0);
        run_one("R2", 32'h4000_0020, 1'b1, 2, 3, 8'd0, 0, 3, 1'b1, 1'b0);
        run_one("R3", 32'h0000_2000, 1'b0, 3, 2, 8'd0, 0, 2, 1'b1, 1'b1);
        run_one("R3", 32'h0000_3000, 1'b1, 4, 1, 8'd0, 0, 1, 1'b1, 1'b1);
        run_one("R4", 32'h0000_4000, 1'b0, 5, 2, 8'd0, 0, 2, 1'b1, 1'b1);
        run_one("R5", 32'h0000_5000, 1'b0, 0, 0, 8'd4, 0, 4, 1'b1, 1'b1);
        run_one("R5", 32'h0000_6000, 1'b0, 1, 4, 8'd4, 0, 4, 1'b1, 1'b1);
        run_one("R5", 32'h0000_7000, 1'b1, 1, 3, 8'd4, 0, 3, 1'b1, 1'b0);
        run_one("R5", 32'h0000_8000, 1'b0, 0, 0, 8'd1, 0, 1, 1'b1, 1'b1);
        run_one("R6", 32'h0000_9000, 1'b0, 1, 3, 8'd0, 1, 3, 1'b0, 1'b0);
        run_one("R6", 32'h0000_A000, 1'b0, 0, 0, 8'd5, 2, 5, 1'b0, 1'b0);
        run_one("R6", 32'h0000_B000, 1'b1, 1, 2, 8'd0, 2, 2, 1'b1, 1'b0);
        test_idle_acks();
        test_busy_request();
        test_cse(32'h00C0_0010, 1'b1, 2'b10);
        test_cse(32'h00C3_0000, 1'b1, 2'b11);
        test_cse(32'h0004_0000, 1'b1, 2'b01);
        test_cse(32'h8000_0000, 1'b1, 2'b00);
        test_cse(32'h00C0_0010, 1'b0, 2'b00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule